// File: doc/BRIEF.md
# Dual-Port Mailbox RAM with Doorbell Interrupts

A 1024-byte, byte-wide RAM that a host bus and an embedded processor share through two independent ports. Each port has its own address, write data, write enable and read enable, and both ports may read and write in the same cycle. The address space holds a fixed map of regions. Some regions belong to one side only, so each side has a place to post messages that the other side cannot overwrite.

Two bytes at the top of the map act as doorbells. When the processor writes the byte at 0x3FE, the host interrupt rises. When the host writes the byte at 0x3FF, the processor interrupt rises. The value written is kept as a code for the receiver to read. The receiver acknowledges by writing 0xFE back to the same byte. That write drops the interrupt, and the sender can read the byte to see that the acknowledge arrived.

A write that the map forbids for a port is discarded. That port's violation flag then pulses for one cycle.

Top module: `mbx_dualport`

## Requirements
- R1: After synchronous reset, every byte reads 0x00, both interrupt lines are low, both violation flags are low and both read-data outputs are 0x00.
- R2: A read with read enable high returns the addressed byte on that port's read data in the next cycle. The value is the one held before any write in the same cycle. With read enable low, the read data keeps its value.
- R3: Processor writes to 0x000–0x3DF, 0x3F0–0x3F3 or 0x3F8–0x3FB are discarded, and the processor violation flag is high for exactly the following cycle.
- R4: Host writes to 0x3F4–0x3F7 are discarded, and the host violation flag is high for exactly the following cycle.
- R5: Bytes 0x3E0–0x3EF and 0x3FC–0x3FD accept writes from both ports. Host-only regions accept host writes, and 0x3F4–0x3F7 accepts processor writes.
- R6: A processor write of any value to 0x3FE stores the value and sets the host interrupt from the next cycle on. The interrupt stays set until it is cleared.
- R7: A host write of any value to 0x3FF stores the value and sets the processor interrupt from the next cycle on. The interrupt stays set until it is cleared.
- R8: A host write of 0xFE to 0x3FE stores 0xFE and clears the host interrupt. A processor write of 0xFE to 0x3FF does the same for 0x3FF and the processor interrupt. A receiver write of any other value to its doorbell is a violation and is discarded.
- R9: A new doorbell write while that interrupt is already set keeps the interrupt set and replaces the stored code.
- R10: When both ports write the same byte in one cycle, the host write is stored and the processor write has no effect. On a doorbell this also covers the interrupt.
- R11: Accepted writes from both ports to different bytes in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 10 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_we | input | 1 | Host write enable |
| h_re | input | 1 | Host read enable |
| h_rdata | output | 8 | Host read data, one cycle after read enable |
| c_addr | input | 10 | Processor byte address |
| c_wdata | input | 8 | Processor write data |
| c_we | input | 1 | Processor write enable |
| c_re | input | 1 | Processor read enable |
| c_rdata | output | 8 | Processor read data, one cycle after read enable |
| irq_to_host | output | 1 | Interrupt to host, set by processor doorbell |
| irq_to_cpu | output | 1 | Interrupt to processor, set by host doorbell |
| h_wr_err | output | 1 | One-cycle pulse after a forbidden host write |
| c_wr_err | output | 1 | One-cycle pulse after a forbidden processor write |

## Verification
The stimulus includes single-port writes into every region from each side. Readback through the other port separates accepted writes from discarded ones, and the violation flags show which side was refused.

Doorbell sequences run in several orders: raise then acknowledge, re-raise while pending, and an acknowledge carrying a wrong value. These separate set, clear and hold behaviour of each interrupt.

Simultaneous traffic covers three cases:
- Same-byte writes, including a doorbell raise and its acknowledge in one cycle, which expose the priority rule.
- Writes to different bytes in one cycle.
- A read and a write to one byte in one cycle, which shows read-before-write ordering.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    localparam logic [ADDR_W-1:0] HOST_MSG_HI  = 10'h3DF;
    localparam logic [ADDR_W-1:0] STAT_PTR_LO  = 10'h3F0;
    localparam logic [ADDR_W-1:0] STAT_PTR_HI  = 10'h3F3;
    localparam logic [ADDR_W-1:0] CPU_MSG_LO   = 10'h3F4;
    localparam logic [ADDR_W-1:0] CPU_MSG_HI   = 10'h3F7;
    localparam logic [ADDR_W-1:0] BLK_ADDR_LO  = 10'h3F8;
    localparam logic [ADDR_W-1:0] BLK_ADDR_HI  = 10'h3FB;
    localparam logic [ADDR_W-1:0] BELL_TO_HOST = 10'h3FE;
    localparam logic [ADDR_W-1:0] BELL_TO_CPU  = 10'h3FF;
    localparam logic [DATA_W-1:0] ACK_CODE     = 8'hFE;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic logic host_may_write(input logic [ADDR_W-1:0] a,
                                            input logic [DATA_W-1:0] d);
        if (a >= CPU_MSG_LO && a <= CPU_MSG_HI) return 1'b0;
        if (a == BELL_TO_HOST) return d == ACK_CODE;
        return 1'b1;
    endfunction

    function automatic logic cpu_may_write(input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
        if (a <= HOST_MSG_HI) return 1'b0;
        if (a >= STAT_PTR_LO && a <= STAT_PTR_HI) return 1'b0;
        if (a >= BLK_ADDR_LO && a <= BLK_ADDR_HI) return 1'b0;
        if (a == BELL_TO_CPU) return d == ACK_CODE;
        return 1'b1;
    endfunction
endpackage

// File: rtl/mbx_guard.sv
module mbx_guard
    import mbx_pkg::*;
#(
    parameter bit IS_HOST = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    output wr_req_t acc,
    output logic    err
);
    logic allowed;

    generate
        if (IS_HOST) begin : g_host
            always_comb allowed = host_may_write(req.addr, req.data);
        end else begin : g_cpu
            always_comb allowed = cpu_may_write(req.addr, req.data);
        end
    endgenerate

    always_comb begin
        acc    = req;
        acc.en = req.en && allowed;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= req.en && !allowed;
    end
endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           h_acc,
    input  wr_req_t           c_acc,
    input  logic [ADDR_W-1:0] h_raddr,
    input  logic              h_re,
    input  logic [ADDR_W-1:0] c_raddr,
    input  logic              c_re,
    output logic [DATA_W-1:0] h_rdata,
    output logic [DATA_W-1:0] c_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              c_lose;

    always_comb c_lose = h_acc.en && (h_acc.addr == c_acc.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (c_acc.en && !c_lose) mem[c_acc.addr] <= c_acc.data;
            if (h_acc.en)            mem[h_acc.addr] <= h_acc.data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rdata <= '0;
            c_rdata <= '0;
        end else begin
            if (h_re) h_rdata <= mem[h_raddr];
            if (c_re) c_rdata <= mem[c_raddr];
        end
    end
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t h_acc,
    input  wr_req_t c_acc,
    output logic    irq_to_host,
    output logic    irq_to_cpu
);
    logic h_hits_hbell, c_hits_hbell, h_hits_cbell, c_hits_cbell;

    always_comb begin
        h_hits_hbell = h_acc.en && h_acc.addr == BELL_TO_HOST;
        c_hits_hbell = c_acc.en && c_acc.addr == BELL_TO_HOST;
        h_hits_cbell = h_acc.en && h_acc.addr == BELL_TO_CPU;
        c_hits_cbell = c_acc.en && c_acc.addr == BELL_TO_CPU;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_to_host <= 1'b0;
            irq_to_cpu  <= 1'b0;
        end else begin
            // host side wins a same-cycle contest on either bell
            if (h_hits_hbell)      irq_to_host <= 1'b0;
            else if (c_hits_hbell) irq_to_host <= 1'b1;
            if (h_hits_cbell)      irq_to_cpu  <= 1'b1;
            else if (c_hits_cbell) irq_to_cpu  <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_dualport.sv
module mbx_dualport
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    input  logic              h_we,
    input  logic              h_re,
    output logic [DATA_W-1:0] h_rdata,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_wdata,
    input  logic              c_we,
    input  logic              c_re,
    output logic [DATA_W-1:0] c_rdata,
    output logic              irq_to_host,
    output logic              irq_to_cpu,
    output logic              h_wr_err,
    output logic              c_wr_err
);
    wr_req_t h_req, c_req, h_acc, c_acc;

    always_comb begin
        h_req = '{en: h_we, addr: h_addr, data: h_wdata};
        c_req = '{en: c_we, addr: c_addr, data: c_wdata};
    end

    mbx_guard #(.IS_HOST(1'b1)) i_hguard (
        .clk(clk), .rst(rst), .req(h_req), .acc(h_acc), .err(h_wr_err));

    mbx_guard #(.IS_HOST(1'b0)) i_cguard (
        .clk(clk), .rst(rst), .req(c_req), .acc(c_acc), .err(c_wr_err));

    mbx_store i_store (
        .clk(clk), .rst(rst), .h_acc(h_acc), .c_acc(c_acc),
        .h_raddr(h_addr), .h_re(h_re), .c_raddr(c_addr), .c_re(c_re),
        .h_rdata(h_rdata), .c_rdata(c_rdata));

    mbx_doorbell i_bell (
        .clk(clk), .rst(rst), .h_acc(h_acc), .c_acc(c_acc),
        .irq_to_host(irq_to_host), .irq_to_cpu(irq_to_cpu));
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] h_addr,
    input logic [DATA_W-1:0] h_wdata,
    input logic              h_we,
    input logic              h_re,
    input logic [DATA_W-1:0] h_rdata,
    input logic [ADDR_W-1:0] c_addr,
    input logic [DATA_W-1:0] c_wdata,
    input logic              c_we,
    input logic              c_re,
    input logic [DATA_W-1:0] c_rdata,
    input logic              irq_to_host,
    input logic              irq_to_cpu,
    input logic              h_wr_err,
    input logic              c_wr_err
);
    // R2
    hold_hrd_chk: assert property (@(posedge clk) disable iff (rst)
        !h_re |=> $stable(h_rdata));
    // R3
    cpu_msg_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (c_we && c_addr <= HOST_MSG_HI) |=> c_wr_err);
    // R4
    host_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (h_we && c_addr != h_addr && h_addr >= CPU_MSG_LO && h_addr <= CPU_MSG_HI) |=> h_wr_err);
    // R6
    raise_host_chk: assert property (@(posedge clk) disable iff (rst)
        (c_we && c_addr == BELL_TO_HOST && !(h_we && h_addr == BELL_TO_HOST)) |=> irq_to_host);
    // R7
    raise_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (h_we && h_addr == BELL_TO_CPU) |=> irq_to_cpu);
    // R8
    ack_host_chk: assert property (@(posedge clk) disable iff (rst)
        (h_we && h_addr == BELL_TO_HOST && h_wdata == ACK_CODE) |=> !irq_to_host);
    // R8
    ack_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (c_we && c_addr == BELL_TO_CPU && c_wdata == ACK_CODE
         && !(h_we && h_addr == BELL_TO_CPU)) |=> !irq_to_cpu);
    // R6
    hold_irq_host_chk: assert property (@(posedge clk) disable iff (rst)
        (!(h_we && h_addr == BELL_TO_HOST) && !(c_we && c_addr == BELL_TO_HOST))
        |=> $stable(irq_to_host));
endmodule

bind mbx_dualport mbx_chk i_chk (.*);

// File: tb/test_mbx_dualport.sv
module test_mbx_dualport;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] h_addr = '0, c_addr = '0;
    logic [7:0] h_wdata = '0, c_wdata = '0;
    logic       h_we = 1'b0, h_re = 1'b0, c_we = 1'b0, c_re = 1'b0;
    logic [7:0] h_rdata, c_rdata;
    logic       irq_to_host, irq_to_cpu, h_wr_err, c_wr_err;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // reference model state
    byte unsigned m_mem [1024];
    byte unsigned m_hr, m_cr;
    bit m_ih, m_ic, m_he, m_ce;

    always #5 clk = ~clk;

    mbx_dualport i_mbx_dualport (.*);

    function automatic bit host_ok(int a, int d);
        if (a >= 'h3F4 && a <= 'h3F7) return 0;
        if (a == 'h3FE) return d == 'hFE;
        return 1;
    endfunction

    function automatic bit cpu_ok(int a, int d);
        if (a < 'h3E0) return 0;
        if (a >= 'h3F0 && a <= 'h3F3) return 0;
        if (a >= 'h3F8 && a <= 'h3FB) return 0;
        if (a == 'h3FF) return d == 'hFE;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_hr = 0; m_cr = 0; m_ih = 0; m_ic = 0; m_he = 0; m_ce = 0;
        end else begin
            bit ha, ca;
            ha = h_we && host_ok(h_addr, h_wdata);
            ca = c_we && cpu_ok(c_addr, c_wdata);
            if (ha && ca && h_addr == c_addr) ca = 0;
            m_he = h_we && !host_ok(h_addr, h_wdata);
            m_ce = c_we && !cpu_ok(c_addr, c_wdata);
            if (h_re) m_hr = m_mem[h_addr];
            if (c_re) m_cr = m_mem[c_addr];
            if (ca) begin
                m_mem[c_addr] = c_wdata;
                if (c_addr == 'h3FE) m_ih = 1;
                if (c_addr == 'h3FF) m_ic = 0;
            end
            if (ha) begin
                m_mem[h_addr] = h_wdata;
                if (h_addr == 'h3FE) m_ih = 0;
                if (h_addr == 'h3FF) m_ic = 1;
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("h_rdata", h_rdata, m_hr);
            check("c_rdata", c_rdata, m_cr);
            check("irq_to_host", irq_to_host, m_ih);
            check("irq_to_cpu", irq_to_cpu, m_ic);
            check("h_wr_err", h_wr_err, m_he);
            check("c_wr_err", c_wr_err, m_ce);
        end
    end

    task automatic cyc(bit hwe, int ha, int hd, bit hre, bit cwe, int ca, int cd, bit cre);
        @(negedge clk); #1;
        h_we = hwe; h_addr = ha[9:0]; h_wdata = hd[7:0]; h_re = hre;
        c_we = cwe; c_addr = ca[9:0]; c_wdata = cd[7:0]; c_re = cre;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic hw(int a, int d); cyc(1, a, d, 0, 0, 0, 0, 0); idle(); endtask
    task automatic cw(int a, int d); cyc(0, 0, 0, 0, 1, a, d, 0); idle(); endtask
    task automatic rd(int a); cyc(0, a, 0, 1, 0, a, 0, 1); idle(); endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #200000;
        checks++; fails++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        idle(); rd('h000); rd('h3FF);

        cur_req = "R2";
        hw('h000, 'h11); hw('h155, 'h22); hw('h3DF, 'h33);
        rd('h000); rd('h155); rd('h3DF);
        cyc(0, 'h155, 0, 1, 0, 0, 0, 0);
        cyc(0, 'h000, 0, 0, 0, 0, 0, 0);
        // read and write of one byte in the same cycle returns old data
        cyc(1, 'h155, 'h99, 1, 0, 0, 0, 1);
        idle(); rd('h155);

        cur_req = "R3";
        cw('h010, 'hAA); cw('h3DF, 'hAB); cw('h3F2, 'hAC); cw('h3F9, 'hAD);
        rd('h010); rd('h3DF); rd('h3F2); rd('h3F9);

        cur_req = "R4";
        hw('h3F5, 'h5A); rd('h3F5);

        cur_req = "R5";
        cw('h3F5, 'h5B); cw('h3E0, 'h61); hw('h3EF, 'h62); cw('h3FC, 'h63);
        hw('h3FD, 'h64); hw('h3F1, 'h65); hw('h3FA, 'h66);
        rd('h3F5); rd('h3E0); rd('h3EF); rd('h3FC); rd('h3FD); rd('h3F1); rd('h3FA);

        cur_req = "R6";
        cw('h3FE, 'h01); repeat (3) idle(); rd('h3FE);
        cur_req = "R9";
        cw('h3FE, 'h07); rd('h3FE);
        cur_req = "R8";
        hw('h3FE, 'h00); rd('h3FE);
        hw('h3FE, 'hFE); rd('h3FE);

        cur_req = "R7";
        hw('h3FF, 'h03); repeat (3) idle(); rd('h3FF);
        cur_req = "R9";
        hw('h3FF, 'h05); rd('h3FF);
        cur_req = "R8";
        cw('h3FF, 'h01); rd('h3FF);
        cw('h3FF, 'hFE); rd('h3FF);

        cur_req = "R10";
        cyc(1, 'h3E4, 'h71, 0, 1, 'h3E4, 'h72, 0); idle(); rd('h3E4);
        cw('h3FE, 'h02);
        cyc(1, 'h3FE, 'hFE, 0, 1, 'h3FE, 'h09, 0); idle(); rd('h3FE);
        hw('h3FF, 'h04);
        cyc(1, 'h3FF, 'h06, 0, 1, 'h3FF, 'hFE, 0); idle(); rd('h3FF);
        cyc(1, 'h3F5, 'h44, 0, 1, 'h3F5, 'h45, 0); idle(); rd('h3F5);

        cur_req = "R11";
        cyc(1, 'h200, 'h81, 0, 1, 'h3E9, 'h82, 0);
        cyc(1, 'h3F0, 'h83, 0, 1, 'h3F6, 'h84, 0);
        idle(); rd('h200); rd('h3E9); rd('h3F0); rd('h3F6);
        cyc(0, 'h200, 0, 1, 0, 'h3E9, 0, 1); idle();

        repeat (2) idle();
        finish_run();
    end
endmodule